// File: doc/BRIEF.md
# I2C Bus Time-out Watchdog

This block watches a byte-oriented I2C controller for a stalled transfer. The controller raises its interrupt flag whenever a new bus state is ready for software. While that flag is low, the controller is working on the bus and is waiting for the next event. If that wait goes on too long, the bus is taken to be hung.

A counter of `CNT_W` bits (14 by default) advances only while the watchdog is enabled and the controller's interrupt flag is low. It is forced to zero whenever that flag is high, so each wait is timed afresh. An optional divide-by-4 stretches the period by a factor of four. When the counter rolls over from its all-ones value, a sticky time-out flag is set. Software clears this flag with a one-cycle clear strobe. An interrupt request follows the flag when the interrupt enable is high.

Control runs through a three-state machine whose state register samples the enable and the interrupt flag once per clock:
- `ST_OFF` (watchdog disabled).
- `ST_HOLD` (enabled, interrupt flag high).
- `ST_RUN` (enabled, interrupt flag low).

The transitions are:
- `OFF->HOLD`: enable rises with the flag high.
- `OFF->RUN`: enable rises with the flag low.
- `HOLD->RUN`: the flag clears, so counting restarts from zero.
- `RUN->HOLD`: the flag sets, so the count is discarded.
- `any->OFF`: enable falls.

The counter and the prescaler count only in `ST_RUN` and are zero in every other state.

Top module: `i2c_tmo_watch`

## Requirements
- R1: After reset the time-out flag and the interrupt request are 0, the counter is zero and the state is `ST_OFF`.
- R2: While the enable is 0, or while the interrupt flag is held at 1 with the enable at 1, no time-out occurs however long that lasts.
- R3: With enable 1, the interrupt flag 0 and divide-by-4 off, the counter advances once per clock. The controls are registered once, so the flag rises on the (1 + 2^CNT_W)-th rising edge after the inputs change, which is edge 16385 by default.
- R4: A 1 on the interrupt flag returns the counter to zero. After the flag returns to 0, the time-out again takes 1 + 2^CNT_W edges measured from that change.
- R5: With divide-by-4 on, the counter advances once every 4 clocks, so the time-out comes 1 + 4*2^CNT_W edges after counting is enabled.
- R6: The time-out flag is sticky. It stays 1 until a clear strobe arrives.
- R7: A clear strobe (1 for a cycle) with no time-out in that cycle makes the flag 0 after the next rising edge.
- R8: After a roll-over, the counter carries on from zero while the interrupt flag stays 0. The next time-out comes exactly 2^CNT_W edges after the previous one.
- R9: When a roll-over and a clear strobe fall in the same cycle, the flag is set.
- R10: The interrupt request equals the time-out flag ANDed with the interrupt enable, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| si_flag | input | 1 | Interrupt-flag level of the I2C controller |
| tmo_en | input | 1 | Watchdog counter enable |
| div4_en | input | 1 | Count once every 4 clocks |
| irq_en | input | 1 | Interrupt enable |
| tmo_clr | input | 1 | Write-one-to-clear strobe for the time-out flag |
| tmo_flag | output | 1 | Sticky time-out flag |
| tmo_irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is synchronous to `clk` and holds a defined level from reset onward. They also assume the clear input is a level sampled on each edge, not a pulse narrower than one clock. The stimulus changes inputs only on falling clock edges and keeps `div4_en` fixed during each counting run, so the prescaler phase stays well defined. Each full-length time-out period is run to completion, so the roll-over, the restart after the interrupt flag and the overlap of set and clear are all reached at the default counter width.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } tmo_state_e;

endpackage

// File: rtl/i2c_tmo_ctrl.sv
module i2c_tmo_ctrl
    import i2c_tmo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tmo_en,
    input  logic       si_flag,
    output tmo_state_e state_q,
    output logic       run
);

    tmo_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (tmo_en && si_flag)       state_d = ST_HOLD;
                else if (tmo_en)             state_d = ST_RUN;
            end
            ST_HOLD: begin
                if (!tmo_en)                 state_d = ST_OFF;
                else if (!si_flag)           state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!tmo_en)                 state_d = ST_OFF;
                else if (si_flag)            state_d = ST_HOLD;
            end
            default:                         state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        run = (state_q == ST_RUN);
    end

    // R2: disabling always lands in the off state
    a_r2_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !tmo_en |=> (state_q == ST_OFF));

    // R4: an active interrupt flag stops counting at the next edge
    a_r4_si_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
        si_flag |=> !run);

endmodule

// File: rtl/i2c_tmo_presc.sv
module i2c_tmo_presc #(
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic div_en,
    output logic tick
);

    localparam int PW = (DIV_LOG2 < 1) ? 1 : DIV_LOG2;
    localparam logic [PW-1:0] PHASE_LAST = {PW{1'b1}};

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 phase_q <= '0;
        else if (run && div_en)     phase_q <= phase_q + 1'b1;
        else                        phase_q <= '0;
    end

    generate
        if (DIV_LOG2 == 0) begin : g_nodiv
            assign tick = run;
        end else begin : g_div
            assign tick = run && (!div_en || (phase_q == PHASE_LAST));
        end
    endgenerate

    // R5: with the divider on, two ticks are never adjacent
    a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_en && $past(div_en) && (DIV_LOG2 > 0)) |=> !tick || !div_en);

    // R2: out of the running state the phase returns to zero
    a_r2_phase_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (phase_q == '0));

endmodule

// File: rtl/i2c_tmo_count.sv
module i2c_tmo_count #(
    parameter int CNT_W = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic wrap
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

    assign wrap = tick && (cnt_q == CNT_TOP);

    // R4: leaving the running state clears the count
    a_r4_zero_outside_run: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

    // R3: no tick, no movement while running
    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (cnt_q == $past(cnt_q)) || !$past(run));

    // R8: the roll-over returns to zero
    a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));

endmodule

// File: rtl/i2c_tmo_flag.sv
module i2c_tmo_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_evt) flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

    // R9: a time-out wins over a simultaneous clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_q);

    // R7: a clear with no set empties the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_evt) |=> !flag_q);

    // R6: the flag does not drop without a clear
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> flag_q);

endmodule

// File: rtl/i2c_tmo_watch.sv
module i2c_tmo_watch
    import i2c_tmo_pkg::*;
#(
    parameter int CNT_W    = 14,
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic si_flag,
    input  logic tmo_en,
    input  logic div4_en,
    input  logic irq_en,
    input  logic tmo_clr,
    output logic tmo_flag,
    output logic tmo_irq
);

    tmo_state_e state_q;
    logic       run;
    logic       tick;
    logic       wrap;

    i2c_tmo_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tmo_en  (tmo_en),
        .si_flag (si_flag),
        .state_q (state_q),
        .run     (run)
    );

    i2c_tmo_presc #(.DIV_LOG2(DIV_LOG2)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .div_en (div4_en),
        .tick   (tick)
    );

    i2c_tmo_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .wrap  (wrap)
    );

    i2c_tmo_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (wrap),
        .clr_req (tmo_clr),
        .flag_q  (tmo_flag)
    );

    assign tmo_irq = tmo_flag && irq_en;

    // R3: a new time-out only follows a cycle spent running
    a_r3_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> $past(run));

    // R10: the request never appears with the enable low
    a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !tmo_irq);

    // R10: the request tracks the flag whenever enabled
    a_r10_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && tmo_flag) |-> tmo_irq);

    // R1: state stays legal after reset
    a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'd3);

endmodule

// File: tb/i2c_tmo_watch_bench.sv
module i2c_tmo_watch_bench;

    localparam int W     = 14;
    localparam int SPAN  = 1 << W;
    localparam int WDOG  = 198000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic si_flag = 1'b0, tmo_en = 1'b0, div4_en = 1'b0, irq_en = 1'b0, tmo_clr = 1'b0;
    logic tmo_flag, tmo_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // behavioural model state
    bit m_active;
    int m_phase;
    int m_count;
    bit m_flag;

    always #10 clk = ~clk;

    i2c_tmo_watch #(.CNT_W(W), .DIV_LOG2(2)) u_i2c_tmo_watch (
        .clk(clk), .rst_n(rst_n), .si_flag(si_flag), .tmo_en(tmo_en),
        .div4_en(div4_en), .irq_en(irq_en), .tmo_clr(tmo_clr),
        .tmo_flag(tmo_flag), .tmo_irq(tmo_irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_active = 1'b0; m_phase = 0; m_count = 0; m_flag = 1'b0;
        end else begin
            bit step;
            step = m_active && (!div4_en || m_phase == 3);
            if (step && m_count == SPAN - 1) m_flag = 1'b1;
            else if (tmo_clr)                m_flag = 1'b0;
            if (!m_active)  m_count = 0;
            else if (step)  m_count = (m_count + 1) % SPAN;
            m_phase  = (m_active && div4_en) ? (m_phase + 1) % 4 : 0;
            m_active = tmo_en && !si_flag;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model (R6, R10)
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            check("R6 flag vs model", tmo_flag, m_flag);
            check("R10 irq vs model", tmo_irq, m_flag && irq_en);
        end
    end

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_rise(output int n, input int limit);
        n = 0;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (tmo_flag) break;
        end
    endtask

    initial begin
        int n;
        @(negedge clk); @(negedge clk);
        check("R1 reset flag", tmo_flag, 1'b0);
        check("R1 reset irq", tmo_irq, 1'b0);
        rst_n = 1'b1;
        edges(2);
        check("R1 flag after release", tmo_flag, 1'b0);

        // R3: plain counting
        tmo_en = 1'b1;
        wait_rise(n, SPAN + 10);
        check_int("R3 edges to time-out", n, SPAN + 1);
        check("R10 irq held low by enable", tmo_irq, 1'b0);
        irq_en = 1'b1;
        #1;
        check("R10 irq follows flag", tmo_irq, 1'b1);
        edges(3);
        check("R6 flag sticky", tmo_flag, 1'b1);

        // R7 clear, R8 continuation (the wrap happened 3 edges ago)
        tmo_clr = 1'b1;
        @(negedge clk);
        tmo_clr = 1'b0;
        check("R7 flag cleared", tmo_flag, 1'b0);
        wait_rise(n, SPAN + 10);
        check_int("R8 second period", n + 4, SPAN);

        // R5: divide by four from a fresh start
        tmo_en = 1'b0; tmo_clr = 1'b1;
        edges(2);
        tmo_clr = 1'b0; div4_en = 1'b1; tmo_en = 1'b1;
        wait_rise(n, 4 * SPAN + 10);
        check_int("R5 divided period", n, 4 * SPAN + 1);

        // R4: interrupt flag restart
        tmo_clr = 1'b1; div4_en = 1'b0; tmo_en = 1'b0;
        edges(2);
        tmo_clr = 1'b0; tmo_en = 1'b1;
        edges(5000);
        si_flag = 1'b1;
        edges(40);
        si_flag = 1'b0;
        wait_rise(n, SPAN + 10);
        check_int("R4 restart after interrupt flag", n, SPAN + 1);

        // R2: long hold under interrupt flag, then disabled
        tmo_clr = 1'b1; si_flag = 1'b1;
        edges(2);
        tmo_clr = 1'b0;
        edges(SPAN + 100);
        check("R2 no time-out while flag high", tmo_flag, 1'b0);
        si_flag = 1'b0; tmo_en = 1'b0;
        edges(SPAN + 100);
        check("R2 no time-out while disabled", tmo_flag, 1'b0);

        // R9: clear held across the roll-over
        tmo_clr = 1'b1; tmo_en = 1'b1;
        wait_rise(n, SPAN + 10);
        check_int("R9 set beats clear timing", n, SPAN + 1);
        check("R9 flag set despite clear", tmo_flag, 1'b1);
        @(negedge clk);
        check("R7 clear after set cycle", tmo_flag, 1'b0);
        tmo_clr = 1'b0;
        edges(2);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles >= WDOG);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule